// File: doc/BRIEF.md
# Load Latency Fast-Path Controller

This block is the timing model of a first-level data-cache load pipeline that can take a speculative short-latency path. In any cycle it can accept one load. Each load carries a tag, a base address, a signed displacement and a flag. The flag says whether the base value was produced directly by an earlier load. Arrays, translation and misses are not modelled, so every load is a hit.

At acceptance the block picks a path for the load. The cache may be indexed from the base alone when three conditions hold: the base came from a load, the displacement is small and non-negative, and the previous accepted load was not replayed. That load is then speculative. If its effective address stays on the base's 4096-byte page, it finishes early. If the address leaves the page, the load is replayed and pays a large penalty. Every other load takes the normal path.

Completions come out on three fixed strobe slots, one for each outcome, so loads with different latencies can finish in the same cycle. A one-cycle replay pulse carries the tag of a failing load. Three saturating counters record clean fast completions, normal completions and replays.

Top module: `lfp_ctrl`

## Requirements
- R1: A load accepted in cycle c takes the fast path when all of these hold: in_from_load=1, 0 <= in_disp < 2048, the effective address is on the same page as the base, and the load is not forced. It raises done_valid[0], with its tag in done_tag[3:0], in cycle c+4 only.
- R2: A load on the normal path raises done_valid[1], with its tag in done_tag[7:4], in cycle c+5.
- R3: A load that qualifies for the fast path but crosses a page is replayed. replay_valid pulses in cycle c+4 with replay_tag equal to the load's tag. done_valid[2], with its tag in done_tag[11:8], is raised in cycle c+10.
- R4: A displacement of 2048 or more always takes the normal path. A displacement of 2047 that stays on the page takes the fast path.
- R5: The same-page test compares address bits 31:12 of the effective address (base plus sign-extended displacement, modulo 2^32) with those of the base. A base ending in 0xFFF with displacement 1 replays. The same displacement from a base ending in 0xF00 completes fast.
- R6: The next load accepted after a replayed load takes the normal path even if it would qualify. The load after that one may take the fast path again. replay_valid is never high in two consecutive cycles.
- R7: A load with in_from_load=0 takes the normal path.
- R8: A load with a negative displacement takes the normal path.
- R9: Completions of different kinds that fall due in the same cycle appear together, each in its own slot with its own tag.
- R10: cnt_fast counts done_valid[0] pulses, cnt_norm counts done_valid[1] pulses and cnt_replay counts replay_valid pulses. Each counter shows a pulse in the cycle after it and holds at all ones once full.
- R11: An active-low rst_n clears the in-flight loads, every strobe, the counters and the forced-normal state. A load that would replay and is then cut off by reset does not force the load after reset onto the normal path.
- R12: A cycle with in_valid=0 starts no load, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A load is offered this cycle |
| in_tag | input | TAG_W | Tag of the offered load |
| in_base | input | ADDR_W | Base address |
| in_disp | input | DISP_W | Signed displacement |
| in_from_load | input | 1 | Base was produced directly by a load |
| replay_valid | output | 1 | Replay pulse |
| replay_tag | output | TAG_W | Tag of the replayed load |
| done_valid | output | 3 | Completion strobes: bit 0 fast, bit 1 normal, bit 2 replayed |
| done_tag | output | 3*TAG_W | Completion tags, slot s at bits s*TAG_W upward |
| cnt_fast | output | CNT_W | Saturating count of fast completions |
| cnt_norm | output | CNT_W | Saturating count of normal completions |
| cnt_replay | output | CNT_W | Saturating count of replays |

## Verification
A load offered in cycle c has its results due at fixed offsets:
- a fast completion in c+4;
- a normal completion in c+5;
- a replay pulse in c+4 and the replayed completion in c+10;
- each counter step one cycle after the strobe that causes it.

The bench keeps a table of expected strobes and tags indexed by absolute cycle number and fills it at drive time from its own path model. It samples on the falling edge, so every cycle's outputs are compared against that cycle's row. An empty row is checked as well, so a strobe that comes early, comes late or should not exist at all shows up as a mismatch in the cycle where it appears.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
   typedef enum logic [1:0] {
      LFP_FAST   = 2'd0,
      LFP_NORM   = 2'd1,
      LFP_REPLAY = 2'd2
   } lfp_path_e;

   localparam int unsigned LFP_SLOTS = 3;
endpackage

// File: rtl/lfp_classify.sv
module lfp_classify
   import lfp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DISP_W     = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned DISP_LIMIT = 2048
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              from_load_i,
   input  logic              force_norm_i,
   output lfp_path_e         path_o
);
   if (DISP_W > ADDR_W) begin : g_bad_disp_w
      $error("lfp_classify: DISP_W must not exceed ADDR_W");
   end
   if (PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("lfp_classify: PAGE_BITS must be below ADDR_W");
   end
   if (DISP_LIMIT < 1 || longint'(DISP_LIMIT) >= (longint'(1) << (DISP_W - 1))) begin : g_bad_lim
      $error("lfp_classify: DISP_LIMIT out of range for DISP_W");
   end

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] eff_addr;
   logic              same_page;
   logic              disp_neg;
   logic              disp_short;
   logic              eligible;

   // sign extension variant chosen by width
   if (DISP_W == ADDR_W) begin : g_ext_none
      assign disp_ext = disp_i;
   end else begin : g_ext_sign
      assign disp_ext = {{(ADDR_W - DISP_W){disp_i[DISP_W-1]}}, disp_i};
   end

   assign eff_addr   = base_i + disp_ext;
   assign same_page  = (eff_addr >> PAGE_BITS) == (base_i >> PAGE_BITS);
   assign disp_neg   = disp_i[DISP_W-1];
   assign disp_short = disp_i < DISP_W'(DISP_LIMIT);
   assign eligible   = from_load_i & ~force_norm_i & ~disp_neg & disp_short;

   always_comb begin
      if (!eligible) begin
         path_o = LFP_NORM;
      end else if (same_page) begin
         path_o = LFP_FAST;
      end else begin
         path_o = LFP_REPLAY;
      end
   end
endmodule

// File: rtl/lfp_lane.sv
module lfp_lane #(
   parameter int unsigned TAG_W = 4,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_v,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_v,
   output logic [TAG_W-1:0] out_tag
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("lfp_lane: DEPTH must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("lfp_lane: TAG_W must be at least 1");
   end

   logic [DEPTH-1:0] v_q;
   logic [TAG_W-1:0] tag_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) begin
            tag_q[i] <= '0;
         end
      end else begin
         v_q[0]   <= in_v;
         tag_q[0] <= in_tag;
         for (int i = 1; i < int'(DEPTH); i++) begin
            v_q[i]   <= v_q[i-1];
            tag_q[i] <= tag_q[i-1];
         end
      end
   end

   assign out_v   = v_q[DEPTH-1];
   assign out_tag = tag_q[DEPTH-1];
endmodule

// File: rtl/lfp_satcnt.sv
module lfp_satcnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   if (W < 1) begin : g_bad_w
      $error("lfp_satcnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != '1)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R10: moves only by single steps, and only after a strobe
   p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1) && $past(inc_i));

   // R10: a full counter stays full
   p_cnt_hold_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/lfp_ctrl.sv
module lfp_ctrl
   import lfp_pkg::*;
#(
   parameter int unsigned TAG_W      = 4,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DISP_W     = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned DISP_LIMIT = 2048,
   parameter int unsigned FAST_LAT   = 4,
   parameter int unsigned NORM_LAT   = 5,
   parameter int unsigned REPLAY_LAT = 10,
   parameter int unsigned CNT_W      = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [TAG_W-1:0]             in_tag,
   input  logic [ADDR_W-1:0]            in_base,
   input  logic [DISP_W-1:0]            in_disp,
   input  logic                         in_from_load,
   output logic                         replay_valid,
   output logic [TAG_W-1:0]             replay_tag,
   output logic [LFP_SLOTS-1:0]         done_valid,
   output logic [LFP_SLOTS*TAG_W-1:0]   done_tag,
   output logic [CNT_W-1:0]             cnt_fast,
   output logic [CNT_W-1:0]             cnt_norm,
   output logic [CNT_W-1:0]             cnt_replay
);
   localparam int unsigned REPLAY_TAIL = REPLAY_LAT - FAST_LAT;

   if (FAST_LAT < 1) begin : g_bad_fast
      $error("lfp_ctrl: FAST_LAT must be at least 1");
   end
   if (NORM_LAT <= FAST_LAT) begin : g_bad_norm
      $error("lfp_ctrl: NORM_LAT must exceed FAST_LAT");
   end
   if (REPLAY_LAT <= NORM_LAT) begin : g_bad_replay
      $error("lfp_ctrl: REPLAY_LAT must exceed NORM_LAT");
   end

   lfp_path_e          path;
   logic               force_q;
   logic [LFP_SLOTS-1:0] lane_in_v;
   logic [LFP_SLOTS-1:0] cnt_inc;
   logic [CNT_W-1:0]   cnt_arr [LFP_SLOTS];

   lfp_classify #(
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .PAGE_BITS (PAGE_BITS),
      .DISP_LIMIT(DISP_LIMIT)
   ) u_cls (
      .base_i      (in_base),
      .disp_i      (in_disp),
      .from_load_i (in_from_load),
      .force_norm_i(force_q),
      .path_o      (path)
   );

   assign lane_in_v[0] = in_valid && (path == LFP_FAST);
   assign lane_in_v[1] = in_valid && (path == LFP_NORM);
   assign lane_in_v[2] = in_valid && (path == LFP_REPLAY);

   // the load after a replayed one is held to the normal path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= 1'b0;
      end else if (in_valid) begin
         force_q <= (path == LFP_REPLAY);
      end
   end

   // direct lanes: fast and normal
   for (genvar k = 0; k < 2; k++) begin : g_direct
      localparam int unsigned LAT = (k == 0) ? FAST_LAT : NORM_LAT;
      lfp_lane #(.TAG_W(TAG_W), .DEPTH(LAT)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_v   (lane_in_v[k]),
         .in_tag (in_tag),
         .out_v  (done_valid[k]),
         .out_tag(done_tag[k*TAG_W +: TAG_W])
      );
   end

   // replay lane: detection stage, then the penalty stages
   lfp_lane #(.TAG_W(TAG_W), .DEPTH(FAST_LAT)) u_rep_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (lane_in_v[2]),
      .in_tag (in_tag),
      .out_v  (replay_valid),
      .out_tag(replay_tag)
   );

   lfp_lane #(.TAG_W(TAG_W), .DEPTH(REPLAY_TAIL)) u_rep_tail (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (replay_valid),
      .in_tag (replay_tag),
      .out_v  (done_valid[2]),
      .out_tag(done_tag[2*TAG_W +: TAG_W])
   );

   assign cnt_inc = {replay_valid, done_valid[1], done_valid[0]};

   for (genvar k = 0; k < int'(LFP_SLOTS); k++) begin : g_cnt
      lfp_satcnt #(.W(CNT_W)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .inc_i(cnt_inc[k]),
         .cnt_o(cnt_arr[k])
      );
   end

   assign cnt_fast   = cnt_arr[0];
   assign cnt_norm   = cnt_arr[1];
   assign cnt_replay = cnt_arr[2];

   // R7: an ALU-produced base never speculates
   p_alu_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_from_load) |-> (path == LFP_NORM));

   // R8: negative displacement never speculates
   p_neg_disp_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_disp[DISP_W-1]) |-> (path == LFP_NORM));

   // R4: long displacement never speculates
   p_long_disp_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_disp[DISP_W-1] && (in_disp >= DISP_W'(DISP_LIMIT)))
      |-> (path == LFP_NORM));

   // R6: a load accepted right after a replayed one takes the normal path
   p_forced_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && $past(in_valid) && $past(path == LFP_REPLAY)) |-> (path == LFP_NORM));

   // R6: replays cannot come back to back
   p_replay_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |=> !replay_valid);
endmodule

// File: tb/lfp_ctrl_tb.sv
module lfp_ctrl_tb;
   localparam int TAG_W = 4;
   localparam int CNT_W = 5;
   localparam int NCYC  = 4096;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic [TAG_W-1:0]     in_tag = '0;
   logic [31:0]          in_base = '0;
   logic [31:0]          in_disp = '0;
   logic                 in_from_load = 1'b0;
   logic                 replay_valid;
   logic [TAG_W-1:0]     replay_tag;
   logic [2:0]           done_valid;
   logic [3*TAG_W-1:0]   done_tag;
   logic [CNT_W-1:0]     cnt_fast, cnt_norm, cnt_replay;

   lfp_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .in_base(in_base), .in_disp(in_disp), .in_from_load(in_from_load),
      .replay_valid(replay_valid), .replay_tag(replay_tag),
      .done_valid(done_valid), .done_tag(done_tag),
      .cnt_fast(cnt_fast), .cnt_norm(cnt_norm), .cnt_replay(cnt_replay)
   );

   always #10 clk = ~clk;

   // slot 0 fast, 1 normal, 2 replayed completion, 3 replay pulse
   bit               ev [4][NCYC];
   logic [TAG_W-1:0] et [4][NCYC];
   string            el [4][NCYC];
   string            dflt [4] = '{"R1", "R2", "R3", "R3"};

   int    t = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   int    mf = 0, mn = 0, mr = 0;
   bit    mforce = 1'b0;
   string ovr = "";

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d %s: actual %0h expected %0h", req, t, what, act, exp);
      end
   endtask

   function automatic int sat(int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   function automatic int model_path(logic [31:0] b, logic [31:0] d, bit fl, bit f);
      logic [31:0] e;
      bit          elig;
      e    = b + d;
      elig = fl && !f && !d[31] && (d < 32'd2048);
      if (!elig) return 1;
      return (e[31:12] == b[31:12]) ? 0 : 2;
   endfunction

   task automatic check_now();
      for (int s = 0; s < 4; s++) begin
         logic             av;
         logic [TAG_W-1:0] at;
         string            lab;
         av  = (s < 3) ? done_valid[s] : replay_valid;
         at  = (s < 3) ? done_tag[s*TAG_W +: TAG_W] : replay_tag;
         lab = ev[s][t] ? el[s][t] : ((ovr != "") ? ovr : dflt[s]);
         chk(lab, $sformatf("slot%0d valid", s), 32'(av), 32'(ev[s][t]));
         if (ev[s][t]) chk(lab, $sformatf("slot%0d tag", s), 32'(at), 32'(et[s][t]));
      end
      chk((ovr == "R11") ? "R11" : "R10", "cnt_fast",   32'(cnt_fast),   32'(mf));
      chk((ovr == "R11") ? "R11" : "R10", "cnt_norm",   32'(cnt_norm),   32'(mn));
      chk((ovr == "R11") ? "R11" : "R10", "cnt_replay", 32'(cnt_replay), 32'(mr));
      if (rst_n) begin
         mf = sat(mf + int'(ev[0][t]));
         mn = sat(mn + int'(ev[1][t]));
         mr = sat(mr + int'(ev[3][t]));
      end
   endtask

   task automatic tick();
      @(negedge clk);
      t++;
      check_now();
   endtask

   task automatic load(bit v, logic [TAG_W-1:0] tg, logic [31:0] b, logic [31:0] d,
                       bit fl, string lab);
      int p, lat;
      tick();
      in_valid     = v;
      in_tag       = tg;
      in_base      = b;
      in_disp      = d;
      in_from_load = fl;
      if (v) begin
         p      = model_path(b, d, fl, mforce);
         mforce = (p == 2);
         lat    = (p == 0) ? 4 : ((p == 1) ? 5 : 10);
         ev[p][t+lat] = 1'b1;
         et[p][t+lat] = tg;
         el[p][t+lat] = lab;
         if (p == 2) begin
            ev[3][t+4] = 1'b1;
            et[3][t+4] = tg;
            el[3][t+4] = lab;
         end
      end
   endtask

   task automatic idle(int n, string lab);
      ovr = lab;
      for (int i = 0; i < n; i++) begin
         load(1'b0, TAG_W'($urandom()), 32'h0000_0FFF, 32'd1, 1'b1, lab);
      end
      ovr = "";
   endtask

   task automatic do_reset();
      tick();
      rst_n    = 1'b0;
      in_valid = 1'b0;
      mforce   = 1'b0;
      mf = 0; mn = 0; mr = 0;
      for (int i = t + 1; i < NCYC; i++) begin
         for (int s = 0; s < 4; s++) ev[s][i] = 1'b0;
      end
      ovr = "R11";
      tick();
      tick();
      rst_n = 1'b1;
      ovr = "";
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd9173));
      // reset state
      ovr = "R11";
      tick(); tick(); tick();
      rst_n = 1'b1;
      ovr = "";

      // R1 clean fast completion
      load(1, 4'h1, 32'h1000_0100, 32'd16, 1, "R1");
      // R7 base from ALU
      load(1, 4'h2, 32'h1000_0100, 32'd16, 0, "R7");
      // R8 negative displacement
      load(1, 4'h3, 32'h1000_0100, -32'sd8, 1, "R8");
      // R4 boundary of displacement
      load(1, 4'h4, 32'h1000_0000, 32'd2048, 1, "R4");
      load(1, 4'h5, 32'h1000_0000, 32'd2047, 1, "R4");
      // R5 page edge: F00+1 fast, FFF+1 replays
      load(1, 4'h6, 32'h2000_0F00, 32'd1, 1, "R5");
      load(1, 4'h7, 32'h2000_0FFF, 32'd1, 1, "R5");
      // R6 next load forced normal, the one after fast again
      load(1, 4'h8, 32'h3000_0000, 32'd4, 1, "R6");
      load(1, 4'h9, 32'h3000_0000, 32'd4, 1, "R6");
      idle(12, "");
      // R9 three completions in one cycle
      load(1, 4'hA, 32'h4000_0FF0, 32'd64, 1, "R9");
      load(1, 4'hB, 32'h4000_0000, 32'd0, 0, "R9");
      load(0, 4'h0, 32'h0, 32'd0, 0, "R9");
      load(0, 4'h0, 32'h0, 32'd0, 0, "R9");
      load(0, 4'h0, 32'h0, 32'd0, 0, "R9");
      load(1, 4'hC, 32'h4000_0000, 32'd0, 0, "R9");
      load(1, 4'hD, 32'h4000_0000, 32'd8, 1, "R9");
      idle(12, "");
      // R12 garbage with in_valid low
      idle(16, "R12");
      // R11 reset with loads in flight, including a would-be replay
      load(1, 4'h1, 32'h5000_0000, 32'd0, 0, "R11");
      load(1, 4'h2, 32'h5000_0FFF, 32'd9, 1, "R11");
      do_reset();
      load(1, 4'h3, 32'h5000_0000, 32'd8, 1, "R11");
      idle(12, "");

      // random traffic
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] b, d;
         int          c;
         b = $urandom();
         if ($urandom_range(0, 1) == 1) b[11:8] = 4'hF;
         c = $urandom_range(0, 9);
         if (c < 6)      d = 32'($urandom_range(0, 2047));
         else if (c < 8) d = 32'd2048 + 32'($urandom_range(0, 20000));
         else            d = -32'($urandom_range(1, 4000));
         load($urandom_range(0, 4) != 0, TAG_W'($urandom()), b, d,
              $urandom_range(0, 3) != 0, "");
      end
      idle(14, "");

      // R10 saturation reached on all counters
      chk("R10", "cnt_fast saturated",   32'(cnt_fast),   32'(CMAX));
      chk("R10", "cnt_norm saturated",   32'(cnt_norm),   32'(CMAX));
      chk("R10", "cnt_replay saturated", 32'(cnt_replay), 32'(CMAX));

      summary();
      $finish;
   end
endmodule